// File: doc/BRIEF.md
# Byte-Banked Core Memory Tile

This block is the private data memory of one processor core. Storage is split into four byte-wide banks, each with its own row address and its own two-bit command, so the four lanes of a 32-bit word can be driven together for a word access or one at a time for a byte access. A request sets its type (read or write, word or byte, signed or unsigned) and gives a 12-bit byte address. The tile turns it into per-bank commands and rows. It takes a new request on every clock cycle and needs no stall or handshake.

For a byte access, address bits [1:0] pick the bank and bits [11:2] pick the row in that bank. For a word access, all four banks use bits [11:2] as the row and bits [1:0] are ignored. Byte k of a word sits on bits [8k+7:8k]. Read data comes from the bank output registers one cycle after the request. A bank that was not read keeps its last output value.

Top module: `byte_bank_tile`

## Requirements
- R1: While reset is asserted, and after its release until the first read, rd_data is 0.
- R2: A word write stores all 32 bits of wr_data at row addr[11:2]. A word read of that row puts the same 32 bits on rd_data in the cycle after the read request.
- R3: A byte write stores wr_data[7:0] in the byte at address addr. Bits [31:8] of wr_data are ignored, and the other three bytes of that row keep their values.
- R4: An unsigned byte read (acc_signed = 0) returns the byte at addr on rd_data[7:0], with rd_data[31:8] = 0, one cycle after the request.
- R5: A signed byte read (acc_signed = 1) returns the byte at addr on rd_data[7:0], with every bit of rd_data[31:8] equal to bit 7 of that byte.
- R6: A word access ignores addr[1:0]. A word written with any value in those bits is read back whole with any other value in them.
- R7: In a cycle with no read request (idle, or a write), rd_data keeps its value into the next cycle.
- R8: The tile accepts one request per cycle with no gaps. A read issued in the cycle right after a write to the same location returns the newly written data.
- R9: Each cycle a bank receives at most one command. A byte access gives a command to exactly one bank, a word access to all four banks, and an idle cycle to none. Command encoding: 00 idle, 01 read, 10 write, 11 treated as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the banks run on the same clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| acc_en | input | 1 | Request valid this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 32-bit word access, 0 = byte access |
| acc_signed | input | 1 | For a byte read: 1 = sign-extend, 0 = zero-extend |
| acc_addr | input | 12 | Byte address; [1:0] selects the lane, [11:2] the row |
| wr_data | input | 32 | Write data; a byte write uses [7:0] only |
| rd_data | output | 32 | Registered read data, valid one cycle after a read |

## Verification
A fault in the lane decode shows up as a byte landing in the wrong lane or spreading into other lanes. The next word read of that row shows this one cycle after the read is issued. A stale bank output register or a wrong extension flag is visible in the first read result after the faulty request. The output-hold rule also exposes any bank that reloads without a read command in the cycle that follows. The sweeps write and read every row, so a row-decode fault cannot stay hidden beyond the sweep that touches it.

// File: rtl/byte_bank_tile.sv
module byte_bank_tile #(
  parameter int ROW_W  = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                acc_en,
  input  logic                                acc_write,
  input  logic                                acc_word,
  input  logic                                acc_signed,
  input  logic [ROW_W+$clog2(LANES)-1:0]      acc_addr,
  input  logic [LANES*LANE_W-1:0]             wr_data,
  output logic [LANES*LANE_W-1:0]             rd_data
);
  localparam int SEL_W  = $clog2(LANES);
  localparam int ADDR_W = ROW_W + SEL_W;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ROW_W;
  localparam logic [1:0] CMD_IDLE = 2'b00;
  localparam logic [1:0] CMD_RD   = 2'b01;
  localparam logic [1:0] CMD_WR   = 2'b10;

  logic [LANES-1:0][1:0]        bank_cmd;
  logic [LANES-1:0][ROW_W-1:0]  bank_row;
  logic [LANES-1:0][LANE_W-1:0] bank_wd;
  logic [LANES-1:0][LANE_W-1:0] bank_q;

  wire [SEL_W-1:0] lane = acc_addr[SEL_W-1:0];
  wire [ROW_W-1:0] row  = acc_addr[ADDR_W-1:SEL_W];
  wire             rd_req = acc_en && !acc_write;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q_r;
    wire hit = acc_en && (acc_word || lane == SEL_W'(g));

    assign bank_cmd[g] = hit ? (acc_write ? CMD_WR : CMD_RD) : CMD_IDLE;
    assign bank_row[g] = row;
    assign bank_wd[g]  = acc_word ? wr_data[g*LANE_W +: LANE_W] : wr_data[LANE_W-1:0];
    assign bank_q[g]   = q_r;

    always_ff @(posedge clk)
      if (bank_cmd[g] == CMD_WR) mem[bank_row[g]] <= bank_wd[g];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     q_r <= '0;
      else if (bank_cmd[g] == CMD_RD) q_r <= mem[bank_row[g]];
  end

  logic             rd_word_q, rd_signed_q;
  logic [SEL_W-1:0] rd_lane_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_word_q   <= 1'b1;
      rd_signed_q <= 1'b0;
      rd_lane_q   <= '0;
    end else if (rd_req) begin
      rd_word_q   <= acc_word;
      rd_signed_q <= acc_signed;
      rd_lane_q   <= lane;
    end

  wire [LANE_W-1:0] sel_b = bank_q[rd_lane_q];
  wire [DATA_W-1:0] ext_b = {{(DATA_W-LANE_W){rd_signed_q & sel_b[LANE_W-1]}}, sel_b};

  assign rd_data = rd_word_q ? bank_q : ext_b;
endmodule

// File: rtl/byte_bank_tile_chk.sv
module byte_bank_tile_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_en,
  input logic                      acc_write,
  input logic                      acc_word,
  input logic                      acc_signed,
  input logic [LANES-1:0][1:0]     bank_cmd,
  input logic [LANES*LANE_W-1:0]   rd_data
);
  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0] act;
  always_comb
    for (int i = 0; i < LANES; i++)
      act[i] = (bank_cmd[i] == 2'b01) || (bank_cmd[i] == 2'b10);

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_data == '0);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_write) |=> $stable(rd_data));

  a_r4_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_write && !acc_word && !acc_signed) |=> rd_data[DATA_W-1:LANE_W] == '0);

  a_r5_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_write && !acc_word && acc_signed)
      |=> rd_data[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){rd_data[LANE_W-1]}});

  a_r9_byte_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_word) |-> $countones(act) == 1);

  a_r9_word_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_word) |-> &act);

  a_r9_idle_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> act == '0);
endmodule

bind byte_bank_tile byte_bank_tile_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_write(acc_write),
  .acc_word(acc_word), .acc_signed(acc_signed), .bank_cmd(bank_cmd), .rd_data(rd_data));

// File: tb/byte_bank_tile_tb.sv
module byte_bank_tile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, wr = 1'b0, word = 1'b0, sgn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd_data;
  logic [7:0]  ref_mem [4096];
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  byte_bank_tile u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(en), .acc_write(wr), .acc_word(word),
    .acc_signed(sgn), .acc_addr(addr), .wr_data(wd), .rd_data(rd_data));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic e, input logic w, input logic wo, input logic s,
                     input logic [11:0] a, input logic [31:0] d);
    en = e; wr = w; word = wo; sgn = s; addr = a; wd = d;
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(input logic [9:0] r);
    return {ref_mem[{r, 2'd3}], ref_mem[{r, 2'd2}], ref_mem[{r, 2'd1}], ref_mem[{r, 2'd0}]};
  endfunction

  function automatic logic [31:0] exp_byte(input logic [11:0] a, input logic s);
    logic [7:0] b = ref_mem[a];
    return {{24{s & b[7]}}, b};
  endfunction

  task automatic wword(input logic [11:0] a, input logic [31:0] d);
    cyc(1, 1, 1, 0, a, d);
    for (int i = 0; i < 4; i++) ref_mem[{a[11:2], 2'(i)}] = d[8*i +: 8];
  endtask

  task automatic wbyte(input logic [11:0] a, input logic [31:0] d);
    cyc(1, 1, 0, 0, a, d);
    ref_mem[a] = d[7:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    check("R1 in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 12'h0, 32'h0);
    check("R1 after release", rd_data, 32'h0);

    // R2 and R6: word writes with varied low address bits, reads with other low bits
    for (int r = 0; r < 1024; r++)
      wword({10'(r), 2'(r)}, (r * 32'h9E3779B1) ^ 32'h5A5A0F0F);
    for (int r = 0; r < 1024; r++) begin
      cyc(1, 0, 1, 0, {10'(r), 2'(r + 1)}, 32'h0);
      check("R2 word readback", rd_data, exp_word(10'(r)));
    end
    wword({10'd77, 2'd3}, 32'hCAFEF00D);
    cyc(1, 0, 1, 0, {10'd77, 2'd1}, 32'h0);
    check("R6 low bits ignored", rd_data, 32'hCAFEF00D);

    // R3: byte writes across all lanes, upper write-data bits filled with junk
    for (int r = 0; r < 256; r++)
      for (int l = 0; l < 4; l++)
        wbyte({10'(r), 2'(l)}, {24'hA5C3E1, 8'((r * 7 + l * 61 + 3) ^ (r >> 1))});
    for (int r = 0; r < 256; r++) begin
      cyc(1, 0, 1, 0, {10'(r), 2'd0}, 32'h0);
      check("R3 byte merge", rd_data, exp_word(10'(r)));
    end
    wword({10'd300, 2'd0}, 32'h11223344);
    wbyte({10'd300, 2'd2}, 32'hFFFFFF99);
    cyc(1, 0, 1, 0, {10'd300, 2'd0}, 32'h0);
    check("R3 neighbours kept", rd_data, 32'h11993344);

    // R4 and R5: unsigned and signed byte reads, back to back
    for (int a = 0; a < 1024; a++) begin
      cyc(1, 0, 0, 0, 12'(a), 32'h0);
      check("R4 zero extend", rd_data, exp_byte(12'(a), 1'b0));
      cyc(1, 0, 0, 1, 12'(a), 32'h0);
      check("R5 sign extend", rd_data, exp_byte(12'(a), 1'b1));
    end

    // R7: output holds across write and idle cycles
    cyc(1, 0, 0, 1, {10'd300, 2'd2}, 32'h0);
    check("R7 setup", rd_data, 32'hFFFFFF99);
    hold = rd_data;
    wword({10'd300, 2'd0}, 32'h00000000);
    check("R7 hold over write", rd_data, hold);
    cyc(0, 0, 0, 0, 12'h0, 32'h0);
    check("R7 hold over idle", rd_data, hold);
    wbyte({10'd5, 2'd1}, 32'h000000EE);
    check("R7 hold over byte write", rd_data, hold);

    // R8: read in the cycle right after a write to the same location
    for (int k = 0; k < 64; k++) begin
      wword({10'(900 + k), 2'd0}, 32'h01010101 * k + 32'h80402010);
      cyc(1, 0, 1, 0, {10'(900 + k), 2'd0}, 32'h0);
      check("R8 word write then read", rd_data, exp_word(10'(900 + k)));
      wbyte({10'(900 + k), 2'(k)}, 32'(k * 3 + 128));
      cyc(1, 0, 0, 0, {10'(900 + k), 2'(k)}, 32'h0);
      check("R8 byte write then read", rd_data, exp_byte({10'(900 + k), 2'(k)}, 1'b0));
    end

    cyc(0, 0, 0, 0, 12'h0, 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule